// File: doc/BRIEF.md
# Reversible Gate Cascade Engine

This block holds a register of `LINES` one-bit wires and pushes it through a stored list of reversible gates, one gate per clock cycle. A host first writes gate words into a program store of `DEPTH` entries. It then pulses `start` with the initial wire value, the list length and the direction. The block reports `busy` while it works, pulses `done` for one cycle, and keeps the final wire value on `result` until the next run.

Every gate in the set except one is its own inverse. This means that playing the same list from the last word back to the first undoes a forward run exactly, scratch lines included. The one gate that is not self-inverse is a fixed three-line permutation. If that gate is met during a backward run, the run stops with an error flag and the wires keep the value they had before it.

The control sequencer has three states. `S_IDLE` waits for `start`. On `start` it moves to `S_RUN`, or straight to `S_DONE` when the length is zero. `S_RUN` steps through the list. It moves to `S_DONE` after the last gate, or on an abort. `S_DONE` always returns to `S_IDLE` after one cycle.

Top module: `rgc_engine`

## Requirements
- R1: While reset is applied and in the first cycle after it, `busy`, `done` and `err` are 0 and `result` is 0.
- R2: The edge that accepts `start` loads `init_val` into the wires. For a list of length L (values above DEPTH are clipped to DEPTH), one gate is applied on each of the next L edges, and `done` is high for exactly the one cycle after the L-th such edge. With L = 0, that cycle is the one right after the accepting edge.
- R3: Gate word layout, MSB first: opcode[2:0], target, second, ctrl[LINES-1:0], pol[LINES-1:0]. Opcode 1 flips the target line. Opcode 2 flips the target line when line `second` is 1, and does nothing when `second` equals the target.
- R4: Opcode 3 flips the target line when every line set in `ctrl` equals its `pol` bit. The target's own bit in `ctrl` is ignored, and an empty mask always fires.
- R5: Opcode 4 exchanges lines target and `second` when every line set in `ctrl`, apart from those two lines, equals its `pol` bit. Otherwise both lines are left as they are.
- R6: Opcode 5 takes A = line target, B = line `second`, C = the lowest-numbered line set in `ctrl` (line 0 if none). It writes target = NOT(A^B^C^AB), second = NOT(B^C^AB^BC), C-line = NOT(A^B^AC).
- R7: With `reverse` = 1 at start, the words are applied from index L-1 down to 0. A backward run of a list without opcode 5, started from a forward result, gives back the forward run's starting value.
- R8: In a backward run, reaching an opcode-5 word ends the run on that edge: `err` goes to 1, the wires are not changed, and `done` follows in the next cycle. `err` holds until the next accepted start, which clears it.
- R9: `start` is ignored while `busy` is 1. `busy` is 1 in both `S_RUN` and `S_DONE`.
- R10: Writes to the program store are dropped while `busy` is 1.
- R11: Opcodes 0, 6 and 7 leave all wires unchanged, whatever their other fields hold.
- R12: In `S_IDLE`, `result` holds the last wire value and `busy` is 0 until the next accepted start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| prog_we | input | 1 | Program store write strobe |
| prog_addr | input | $clog2(DEPTH) | Program store write index |
| prog_data | input | 3+2*$clog2(LINES)+2*LINES | Gate word to write |
| prog_len | input | $clog2(DEPTH+1) | Number of gate words to run |
| start | input | 1 | Begin a run (accepted only when idle) |
| reverse | input | 1 | Run the list from last word to first |
| init_val | input | LINES | Starting wire value |
| busy | output | 1 | Run in progress or finishing |
| done | output | 1 | One-cycle end-of-run pulse |
| err | output | 1 | Backward run aborted on a non-self-inverse gate |
| result | output | LINES | Current wire value |

## Verification
Any wrong gate evaluation shows on `result` at the `done` pulse, and the per-cycle model also catches it on the edge where it happens. A wrong step of the program counter, or a wrong walk direction, shows as a mismatch on the next gate that does not commute with the correct one. The backward round trip exposes any gate that is not its own inverse. A miscounted length moves `done` by at least one cycle, and that is seen in the same cycle.

// File: rtl/rgc_pkg.sv
package rgc_pkg;

    typedef enum logic [2:0] {
        OP_NOP  = 3'd0,
        OP_NOT  = 3'd1,
        OP_CNOT = 3'd2,
        OP_TOF  = 3'd3,
        OP_FRED = 3'd4,
        OP_KERN = 3'd5,
        OP_RSV6 = 3'd6,
        OP_RSV7 = 3'd7
    } rgc_op_e;

    typedef enum logic [1:0] {
        S_IDLE = 2'd0,
        S_RUN  = 2'd1,
        S_DONE = 2'd2
    } rgc_state_e;

endpackage

// File: rtl/rgc_prog_store.sv
module rgc_prog_store #(
    parameter int DEPTH = 64,
    parameter int IW    = 25,
    localparam int AW   = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [IW-1:0] wdata,
    input  logic [AW-1:0] raddr,
    output logic [IW-1:0] rdata
);

    logic [IW-1:0] mem_q [DEPTH];

    always_ff @(posedge clk) begin
        if (we) begin
            mem_q[waddr] <= wdata;
        end
    end

    assign rdata = mem_q[raddr];

endmodule

// File: rtl/rgc_gate_eval.sv
module rgc_gate_eval
    import rgc_pkg::*;
#(
    parameter int LINES = 8,
    localparam int LW   = $clog2(LINES),
    localparam int IW   = 3 + 2*LW + 2*LINES
) (
    input  logic [LINES-1:0] in_w,
    input  logic [IW-1:0]    instr,
    output logic [LINES-1:0] out_w,
    output logic             is_kern
);

    rgc_op_e          op;
    logic [LW-1:0]    tgt;
    logic [LW-1:0]    sec;
    logic [LINES-1:0] ctrl;
    logic [LINES-1:0] pol;
    logic [LINES-1:0] tgt_oh;
    logic [LINES-1:0] sec_oh;
    logic [LINES-1:0] eff_mask;
    logic             hit;
    logic [LW-1:0]    cidx;
    logic             ka, kb, kc;

    assign op     = rgc_op_e'(instr[IW-1 -: 3]);
    assign tgt    = instr[2*LINES+2*LW-1 -: LW];
    assign sec    = instr[2*LINES+LW-1 -: LW];
    assign ctrl   = instr[2*LINES-1 -: LINES];
    assign pol    = instr[LINES-1:0];
    assign tgt_oh = LINES'(1) << tgt;
    assign sec_oh = LINES'(1) << sec;

    // Lines that take part in the condition: the moving lines never gate themselves.
    assign eff_mask = (op == OP_FRED) ? (ctrl & ~tgt_oh & ~sec_oh) : (ctrl & ~tgt_oh);
    assign hit      = &(~eff_mask | ~(in_w ^ pol));

    always_comb begin
        cidx = '0;
        for (int i = LINES-1; i >= 0; i--) begin
            if (ctrl[i]) begin
                cidx = LW'(i);
            end
        end
    end

    assign ka = in_w[tgt];
    assign kb = in_w[sec];
    assign kc = in_w[cidx];

    always_comb begin
        out_w = in_w;
        unique case (op)
            OP_NOT:  out_w[tgt] = ~in_w[tgt];
            OP_CNOT: if (sec != tgt && in_w[sec]) out_w[tgt] = ~in_w[tgt];
            OP_TOF:  if (hit) out_w[tgt] = ~in_w[tgt];
            OP_FRED: if (hit) begin
                out_w[tgt] = in_w[sec];
                out_w[sec] = in_w[tgt];
            end
            OP_KERN: begin
                out_w[tgt]  = ~(ka ^ kb ^ kc ^ (ka & kb));
                out_w[sec]  = ~((ka & kb) ^ kb ^ kc ^ (kb & kc));
                out_w[cidx] = ~(ka ^ kb ^ (ka & kc));
            end
            default: out_w = in_w;
        endcase
    end

    assign is_kern = (op == OP_KERN);

    // Guards on the gate outputs against the wires they came from.
    always_comb begin
        if (!$isunknown(in_w) && !$isunknown(instr)) begin
            if (op == OP_FRED) begin
                p_fred_conserves_r5: assert ($countones(out_w) == $countones(in_w));
            end
            if (op == OP_NOT || op == OP_CNOT || op == OP_TOF) begin
                p_single_flip_r4: assert ($countones(out_w ^ in_w) <= 1);
            end
            if (op == OP_NOP || op == OP_RSV6 || op == OP_RSV7) begin
                p_reserved_idle_r11: assert (out_w == in_w);
            end
        end
    end

endmodule

// File: rtl/rgc_engine.sv
module rgc_engine
    import rgc_pkg::*;
#(
    parameter int LINES = 8,
    parameter int DEPTH = 64,
    localparam int LW   = $clog2(LINES),
    localparam int AW   = $clog2(DEPTH),
    localparam int CW   = $clog2(DEPTH + 1),
    localparam int IW   = 3 + 2*LW + 2*LINES
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             prog_we,
    input  logic [AW-1:0]    prog_addr,
    input  logic [IW-1:0]    prog_data,
    input  logic [CW-1:0]    prog_len,
    input  logic             start,
    input  logic             reverse,
    input  logic [LINES-1:0] init_val,
    output logic             busy,
    output logic             done,
    output logic             err,
    output logic [LINES-1:0] result
);

    rgc_state_e       state_q, state_d;
    logic [LINES-1:0] wires_q, wires_d;
    logic [AW-1:0]    pc_q, pc_d;
    logic [CW-1:0]    left_q, left_d;
    logic             rev_q, rev_d;
    logic             err_q, err_d;
    logic [CW-1:0]    len_eff;
    logic [IW-1:0]    cur_instr;
    logic [LINES-1:0] gate_out;
    logic             gate_kern;
    logic             store_we;

    assign len_eff  = (prog_len > CW'(DEPTH)) ? CW'(DEPTH) : prog_len;
    assign store_we = prog_we && (state_q == S_IDLE);

    rgc_prog_store #(.DEPTH(DEPTH), .IW(IW)) store_i (
        .clk   (clk),
        .we    (store_we),
        .waddr (prog_addr),
        .wdata (prog_data),
        .raddr (pc_q),
        .rdata (cur_instr)
    );

    rgc_gate_eval #(.LINES(LINES)) eval_i (
        .in_w    (wires_q),
        .instr   (cur_instr),
        .out_w   (gate_out),
        .is_kern (gate_kern)
    );

    // Next-state and datapath decisions.
    always_comb begin
        state_d = state_q;
        wires_d = wires_q;
        pc_d    = pc_q;
        left_d  = left_q;
        rev_d   = rev_q;
        err_d   = err_q;
        unique case (state_q)
            S_IDLE: begin
                if (start) begin
                    wires_d = init_val;
                    rev_d   = reverse;
                    err_d   = 1'b0;
                    left_d  = len_eff;
                    pc_d    = reverse ? AW'(len_eff - CW'(1)) : '0;
                    state_d = (len_eff == '0) ? S_DONE : S_RUN;
                end
            end
            S_RUN: begin
                if (rev_q && gate_kern) begin
                    err_d   = 1'b1;
                    state_d = S_DONE;
                end else begin
                    wires_d = gate_out;
                    left_d  = left_q - CW'(1);
                    pc_d    = rev_q ? (pc_q - AW'(1)) : (pc_q + AW'(1));
                    if (left_q == CW'(1)) begin
                        state_d = S_DONE;
                    end
                end
            end
            S_DONE:  state_d = S_IDLE;
            default: state_d = S_IDLE;
        endcase
    end

    // State register.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= S_IDLE;
            wires_q <= '0;
            pc_q    <= '0;
            left_q  <= '0;
            rev_q   <= 1'b0;
            err_q   <= 1'b0;
        end else begin
            state_q <= state_d;
            wires_q <= wires_d;
            pc_q    <= pc_d;
            left_q  <= left_d;
            rev_q   <= rev_d;
            err_q   <= err_d;
        end
    end

    // Outputs.
    always_comb begin
        busy   = (state_q != S_IDLE);
        done   = (state_q == S_DONE);
        err    = err_q;
        result = wires_q;
    end

    p_done_single_r2: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    p_err_needs_reverse_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(err) |-> rev_q);

    p_abort_keeps_wires_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(err) |-> $stable(result));

    p_idle_holds_r12: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && !start) |=> $stable(result));

    p_busy_keeps_dir_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !done) |=> $stable(rev_q));

endmodule

// File: tb/rgc_engine_tb_top.sv
module rgc_engine_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        prog_we = 1'b0;
    logic [5:0]  prog_addr = '0;
    logic [24:0] prog_data = '0;
    logic [6:0]  prog_len = '0;
    logic        start = 1'b0;
    logic        reverse = 1'b0;
    logic [7:0]  init_val = '0;
    logic        busy, done, err;
    logic [7:0]  result;

    int total = 0;
    int bad   = 0;
    bit fin   = 0;

    always #2 clk = ~clk;

    rgc_engine #(.LINES(8), .DEPTH(64)) dut_i (
        .clk(clk), .rst_n(rst_n), .prog_we(prog_we), .prog_addr(prog_addr),
        .prog_data(prog_data), .prog_len(prog_len), .start(start),
        .reverse(reverse), .init_val(init_val), .busy(busy), .done(done),
        .err(err), .result(result)
    );

    function automatic logic [24:0] mk(int op, int t, int s, logic [7:0] c, logic [7:0] p);
        return {op[2:0], t[2:0], s[2:0], c, p};
    endfunction

    function automatic logic [7:0] ref_apply(logic [7:0] w, logic [24:0] ins);
        int op, t, s, ci;
        logic [7:0] c, p, r;
        bit hit, a, b, k;
        op = int'(ins[24:22]); t = int'(ins[21:19]); s = int'(ins[18:16]);
        c = ins[15:8]; p = ins[7:0]; r = w; hit = 1; ci = 0;
        case (op)
            1: r[t] = ~w[t];
            2: if (s != t && w[s]) r[t] = ~w[t];
            3, 4: begin
                for (int i = 0; i < 8; i++)
                    if (c[i] && i != t && !(op == 4 && i == s) && w[i] != p[i]) hit = 0;
                if (hit && op == 3) r[t] = ~w[t];
                if (hit && op == 4) begin r[t] = w[s]; r[s] = w[t]; end
            end
            5: begin
                for (int i = 7; i >= 0; i--) if (c[i]) ci = i;
                a = w[t]; b = w[s]; k = w[ci];
                r[t]  = 1 ^ a ^ b ^ k ^ (a & b);
                r[s]  = 1 ^ (a & b) ^ b ^ k ^ (b & k);
                r[ci] = 1 ^ a ^ b ^ (a & k);
            end
            default: ;
        endcase
        return r;
    endfunction

    // Behavioural reference, advanced on every clock.
    logic [24:0] m_mem [64];
    int          m_state = 0, m_pc = 0, m_left = 0, m_len;
    bit          m_rev = 0, m_err = 0;
    logic [7:0]  m_w = '0;

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_state <= 0; m_w <= '0; m_err <= 0; m_rev <= 0;
        end else begin
            case (m_state)
                0: begin
                    if (prog_we) m_mem[prog_addr] <= prog_data;
                    if (start) begin
                        m_len = (prog_len > 64) ? 64 : int'(prog_len);
                        m_w <= init_val; m_rev <= reverse; m_err <= 0;
                        m_left <= m_len;
                        m_pc <= reverse ? m_len - 1 : 0;
                        m_state <= (m_len == 0) ? 2 : 1;
                    end
                end
                1: begin
                    if (m_rev && m_mem[m_pc][24:22] == 3'd5) begin
                        m_err <= 1; m_state <= 2;
                    end else begin
                        m_w <= ref_apply(m_w, m_mem[m_pc]);
                        m_left <= m_left - 1;
                        m_pc <= m_rev ? m_pc - 1 : m_pc + 1;
                        if (m_left == 1) m_state <= 2;
                    end
                end
                default: m_state <= 0;
            endcase
        end
    end

    task automatic check(bit ok, string tag, int act, int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
        end
    endtask

    always @(negedge clk) begin
        if (rst_n && !fin) begin
            check({busy, done, err, result} == {m_state != 0, m_state == 2, m_err, m_w},
                  "R12 per-cycle model", int'({busy, done, err, result}),
                  int'({m_state != 0, m_state == 2, m_err, m_w}));
        end
    end

    task automatic load(int a, logic [24:0] ins);
        @(negedge clk);
        prog_we = 1; prog_addr = 6'(a); prog_data = ins;
        @(negedge clk);
        prog_we = 0;
    endtask

    task automatic run(int len, bit rev, logic [7:0] init, logic [7:0] exp_res,
                       bit exp_err, int exp_cyc, string tag);
        int cyc;
        @(negedge clk);
        prog_len = 7'(len); reverse = rev; init_val = init; start = 1;
        @(negedge clk);
        start = 0; cyc = 1;
        while (!done && cyc < 300) begin
            @(negedge clk);
            cyc++;
        end
        check(cyc == exp_cyc, {tag, " R2 done timing"}, cyc, exp_cyc);
        check(result == exp_res, {tag, " result"}, int'(result), int'(exp_res));
        check(err == exp_err, {tag, " err"}, int'(err), int'(exp_err));
    endtask

    initial begin
        repeat (3) @(negedge clk);
        check({busy, done, err, result} == '0, "R1 reset outputs", int'({busy, done, err, result}), 0);
        rst_n = 1;
        @(negedge clk);
        check({busy, done, err, result} == '0, "R1 after reset", int'({busy, done, err, result}), 0);

        // R3: NOT, CNOT, CNOT onto itself
        load(0, mk(1, 0, 0, 8'h00, 8'h00));
        load(1, mk(2, 1, 0, 8'h00, 8'h00));
        load(2, mk(2, 2, 2, 8'h00, 8'h00));
        run(3, 0, 8'h00, 8'h03, 0, 4, "R3 not/cnot");

        // R4: polarity pattern 010 on lines 2..0, target excluded from mask
        load(0, mk(3, 3, 0, 8'h07, 8'h02));
        load(1, mk(3, 3, 0, 8'h0F, 8'h02));
        run(1, 0, 8'h02, 8'h0A, 0, 2, "R4 match");
        run(1, 0, 8'h03, 8'h03, 0, 2, "R4 no match");
        run(2, 0, 8'h02, 8'h02, 0, 3, "R4 target in mask");

        // R5: controlled exchange
        load(0, mk(4, 1, 2, 8'h01, 8'h01));
        run(1, 0, 8'h03, 8'h05, 0, 2, "R5 swap");
        run(1, 0, 8'h02, 8'h02, 0, 2, "R5 pass");
        load(0, mk(4, 1, 2, 8'h01, 8'h00));
        run(1, 0, 8'h02, 8'h04, 0, 2, "R5 low polarity");

        // R6: three-line permutation gate
        load(0, mk(5, 0, 1, 8'h04, 8'h00));
        run(1, 0, 8'h06, 8'h01, 0, 2, "R6 abc=011");
        run(1, 0, 8'h00, 8'h07, 0, 2, "R6 abc=000");
        load(0, mk(5, 0, 1, 8'h14, 8'h00));
        run(1, 0, 8'h11, 8'h12, 0, 2, "R6 lowest ctrl");

        // R7: order and round trip
        load(0, mk(1, 0, 0, 8'h00, 8'h00));
        load(1, mk(2, 1, 0, 8'h00, 8'h00));
        run(2, 0, 8'h00, 8'h03, 0, 3, "R7 forward order");
        run(2, 1, 8'h00, 8'h01, 0, 3, "R7 backward order");
        load(0, mk(3, 3, 0, 8'h07, 8'h05));
        load(1, mk(4, 4, 5, 8'h08, 8'h08));
        load(2, mk(2, 6, 3, 8'h00, 8'h00));
        load(3, mk(1, 7, 0, 8'h00, 8'h00));
        load(4, mk(2, 0, 7, 8'h00, 8'h00));
        run(5, 0, 8'h35, 8'hFC, 0, 6, "R7 forward mix");
        run(5, 1, 8'hFC, 8'h35, 0, 6, "R7 round trip");

        // R8: abort on permutation gate in a backward run
        load(0, mk(1, 0, 0, 8'h00, 8'h00));
        load(1, mk(5, 0, 1, 8'h04, 8'h00));
        load(2, mk(1, 1, 0, 8'h00, 8'h00));
        run(3, 1, 8'h00, 8'h02, 1, 3, "R8 abort");
        run(3, 0, 8'h00, 8'h00, 0, 4, "R8 forward allowed");

        // R11: reserved codes
        load(0, mk(0, 2, 3, 8'hFF, 8'h0F));
        load(1, mk(6, 1, 4, 8'hAA, 8'h55));
        load(2, mk(7, 5, 6, 8'h33, 8'hCC));
        run(3, 0, 8'h5A, 8'h5A, 0, 4, "R11 reserved");

        // R2: zero length
        run(0, 0, 8'h77, 8'h77, 0, 1, "R2 empty list");

        // R9 and R10: start and writes while busy
        for (int i = 0; i < 10; i++) load(i, mk(1, i % 4, 0, 8'h00, 8'h00));
        fork
            run(10, 0, 8'h00, 8'h03, 0, 11, "R9 start ignored");
            begin
                repeat (4) @(negedge clk);
                start = 1; init_val = 8'hFF; reverse = 1;
                prog_we = 1; prog_addr = 0; prog_data = mk(0, 0, 0, 8'h00, 8'h00);
                @(negedge clk);
                start = 0; prog_we = 0; reverse = 0;
            end
        join
        run(10, 0, 8'h00, 8'h03, 0, 11, "R10 write dropped");

        // R12: hold after done
        repeat (5) @(negedge clk);
        check(result == 8'h03, "R12 result held", int'(result), 3);
        check(busy == 0, "R12 idle not busy", int'(busy), 0);

        fin = 1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (50000) @(posedge clk);
        fin = 1;
        total++; bad++;
        $display("FAIL watchdog expired act=0 exp=1");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule